// File: doc/BRIEF.md
# Accumulator Half-LSB Rounding Unit

This unit rounds a 40-bit accumulator word so that its upper part, from bit 16 up, becomes the rounded result. It adds half of one result LSB (0x8000) to the incoming word. A mode input chooses what happens on an exact tie, which is a low half-word of 0x8000. In biased mode a tie always rounds up. In unbiased mode a tie rounds to an even upper part, because bit 16 of the sum is forced to zero. In every case the low 16 bits keep the value of the sum. They are not cleared.

The same path serves two uses. It can round a freshly produced multiply or accumulate result. It can also round the current accumulator contents in place, which amounts to an accumulate with a zero product. For both uses, the overflow flag is worked out again from the rounded word. The flag is set when the top nine bits (39 down to 31) are not all equal. Each valid input produces one registered result, with a matching output-valid pulse, on the next clock edge.

Top module: `acc_round_unit`

## Requirements
- R1: The unit adds 0x8000 to the 40-bit input. When the low 16 input bits are not 0x8000, the output equals that sum exactly, and the low 16 output bits are the low bits of the sum rather than zeros. For example, 0x00_0000_8001 gives 0x00_0001_0001 and 0x00_0000_7FFF gives 0x00_0000_FFFF.
- R2: In unbiased mode, an input whose low 16 bits equal 0x8000 produces the sum with bit 16 forced to 0. For example, 0x00_0000_8000 gives 0 and 0x00_0001_8000 gives 0x00_0002_0000.
- R3: In biased mode, an input whose low 16 bits equal 0x8000 is rounded up. Bits 39:16 increase by one and bits 15:0 become 0. For example, 0x00_0000_8000 gives 0x00_0001_0000.
- R4: bias_mode = 0 selects unbiased rounding and bias_mode = 1 selects biased rounding. The same tie input therefore gives results that differ only in bit 16.
- R5: ovf_out is 1 exactly when bits 39:31 of the rounded output are neither all zeros nor all ones.
- R6: A result appears on acc_out and ovf_out one clock edge after in_valid is sampled high. out_valid is high for exactly the cycles that follow a cycle with in_valid high.
- R7: While in_valid is low, acc_out and ovf_out keep their values, whatever acc_in and bias_mode do.
- R8: While reset is active, and after it, until the first valid input, out_valid, acc_out and ovf_out are 0.
- R9: The addition wraps modulo 2^40. For example, 0xFF_FFFF_8000 gives 0x00_0000_0000 in both modes, with ovf_out = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously inside the unit |
| in_valid | input | 1 | High for one cycle per word to be rounded |
| acc_in | input | 40 | Accumulator word to be rounded |
| bias_mode | input | 1 | Tie handling: 0 gives unbiased (round to even), 1 gives biased (round up) |
| out_valid | output | 1 | High in the cycle after an accepted input |
| acc_out | output | 40 | Rounded word |
| ovf_out | output | 1 | Set when the top nine bits of acc_out are not uniform |

## Verification
Every result sits behind a single register, so acc_out, ovf_out and out_valid all change on the first rising edge after in_valid is sampled high. The bench drives each input on a falling edge. It reads the outputs on the next falling edge, which is half a period after the capturing edge, and then drops in_valid. On the falling edge after that it checks that out_valid has fallen and that acc_out holds its value, even though acc_in and bias_mode were changed while in_valid was low. Reset values are read while reset is held and again after it is released, before any input is accepted.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;

  // Tie handling selected by the mode pin
  typedef enum logic {
    RND_UNBIASED = 1'b0,
    RND_BIASED   = 1'b1
  } rnd_mode_e;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_rnd_core.sv
module acc_rnd_core
  import acc_rnd_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int RND_POS = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  input  rnd_mode_e        mode_i,
  output logic [ACC_W-1:0] rnd_o
);

  localparam logic [ACC_W-1:0]   HALF_LSB = ACC_W'(1) << (RND_POS - 1);
  localparam logic [RND_POS-1:0] TIE_LO   = HALF_LSB[RND_POS-1:0];

  logic [ACC_W-1:0] sum;
  logic             tie;

  always_comb begin
    sum = acc_i + HALF_LSB;  // wraps modulo 2^ACC_W
    tie = (acc_i[RND_POS-1:0] == TIE_LO);
    rnd_o = sum;
    // Round-to-even on an exact tie: drop the increment's odd bit
    if (tie && (mode_i == RND_UNBIASED)) begin
      rnd_o[RND_POS] = 1'b0;
    end
  end

endmodule

// File: rtl/acc_ovf_detect.sv
module acc_ovf_detect #(
  parameter int ACC_W    = 40,
  parameter int SIGN_POS = 31
) (
  input  logic [ACC_W-1:0] val_i,
  output logic             ovf_o
);

  localparam int GUARD_W = ACC_W - SIGN_POS;

  logic [GUARD_W-1:0] guard;
  logic               all_zero;
  logic               all_one;

  always_comb begin
    guard    = val_i[ACC_W-1:SIGN_POS];
    all_zero = (guard == '0);
    all_one  = (guard == '1);
    ovf_o    = !(all_zero || all_one);
  end

endmodule

// File: rtl/acc_round_unit.sv
module acc_round_unit
  import acc_rnd_pkg::*;
#(
  parameter int ACC_W    = 40,
  parameter int RND_POS  = 16,
  parameter int SIGN_POS = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             bias_mode,
  output logic             out_valid,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf_out
);

  localparam int                 UPPER_W = ACC_W - RND_POS;
  localparam logic [RND_POS-1:0] TIE_LO  = RND_POS'(1) << (RND_POS - 1);

  logic             rst_int_n;
  logic [ACC_W-1:0] rnd_val;
  logic             rnd_ovf;

  logic             vld_q, vld_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             ovf_q, ovf_d;

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  acc_rnd_core #(.ACC_W(ACC_W), .RND_POS(RND_POS)) u_core (
    .acc_i  (acc_in),
    .mode_i (rnd_mode_e'(bias_mode)),
    .rnd_o  (rnd_val)
  );

  acc_ovf_detect #(.ACC_W(ACC_W), .SIGN_POS(SIGN_POS)) u_ovf (
    .val_i (rnd_val),
    .ovf_o (rnd_ovf)
  );

  // Next-state: load on in_valid, otherwise hold
  always_comb begin
    vld_d = in_valid;
    acc_d = acc_q;
    ovf_d = ovf_q;
    if (in_valid) begin
      acc_d = rnd_val;
      ovf_d = rnd_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign out_valid = vld_q;
  assign acc_out   = acc_q;
  assign ovf_out   = ovf_q;

  p_low_kept_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && acc_in[RND_POS-1:0] != TIE_LO) |=>
      acc_out[RND_POS-1:0] == RND_POS'($past(acc_in[RND_POS-1:0]) + TIE_LO));

  p_tie_even_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !bias_mode && acc_in[RND_POS-1:0] == TIE_LO) |=>
      (acc_out[RND_POS] == 1'b0) && (acc_out[RND_POS-1:0] == '0));

  p_tie_up_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && bias_mode && acc_in[RND_POS-1:0] == TIE_LO) |=>
      acc_out[ACC_W-1:RND_POS] == UPPER_W'($past(acc_in[ACC_W-1:RND_POS]) + 1'b1));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> (ovf_out == ((acc_out[ACC_W-1:SIGN_POS] != '0) &&
                               (acc_out[ACC_W-1:SIGN_POS] != '1))));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> ($stable(acc_out) && $stable(ovf_out) && !out_valid));

endmodule

// File: tb/test_acc_round_unit.sv
module test_acc_round_unit;

  typedef struct packed {
    logic [39:0] din;
    logic        mode;
    logic [39:0] exp;
    logic        eovf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{40'h00_0000_8000, 1'b1, 40'h00_0001_0000, 1'b0, 4'd3}, // R3 tie up
    '{40'h00_0000_8000, 1'b0, 40'h00_0000_0000, 1'b0, 4'd2}, // R2 tie even
    '{40'h00_0001_8000, 1'b0, 40'h00_0002_0000, 1'b0, 4'd2}, // R2 odd upper
    '{40'h00_0001_8000, 1'b1, 40'h00_0002_0000, 1'b0, 4'd3}, // R3
    '{40'h00_0000_8001, 1'b0, 40'h00_0001_0001, 1'b0, 4'd1}, // R1 low kept
    '{40'h00_0000_7FFF, 1'b1, 40'h00_0000_FFFF, 1'b0, 4'd1}, // R1
    '{40'h00_0001_7FFF, 1'b0, 40'h00_0001_FFFF, 1'b0, 4'd1}, // R1
    '{40'h00_7FFE_8000, 1'b0, 40'h00_7FFE_0000, 1'b0, 4'd2}, // R2 bit16 cleared
    '{40'h00_7FFF_8000, 1'b1, 40'h00_8000_0000, 1'b1, 4'd5}, // R5 positive spill
    '{40'hFF_7FFF_7FFF, 1'b0, 40'hFF_7FFF_FFFF, 1'b1, 4'd5}, // R5 negative spill
    '{40'hFF_8000_0000, 1'b1, 40'hFF_8000_8000, 1'b0, 4'd5}, // R5 in range
    '{40'hFF_FFFF_8000, 1'b1, 40'h00_0000_0000, 1'b0, 4'd9}, // R9 wrap
    '{40'hFF_FFFF_8000, 1'b0, 40'h00_0000_0000, 1'b0, 4'd9}, // R9 wrap
    '{40'h12_3456_8000, 1'b0, 40'h12_3456_0000, 1'b1, 4'd4}, // R4 mode 0
    '{40'h12_3456_8000, 1'b1, 40'h12_3457_0000, 1'b1, 4'd4}  // R4 mode 1
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [39:0] acc_in;
  logic        bias_mode;
  logic        out_valid;
  logic [39:0] acc_out;
  logic        ovf_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  acc_round_unit i_acc_round_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .acc_in    (acc_in),
    .bias_mode (bias_mode),
    .out_valid (out_valid),
    .acc_out   (acc_out),
    .ovf_out   (ovf_out)
  );

  task automatic chk(input string req, input logic [40:0] act, input logic [40:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [39:0] held;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    acc_in    = '0;
    bias_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R8: state during reset
    chk("R8 during reset", {out_valid, acc_out}, 41'd0);
    chk("R8 ovf during reset", {40'd0, ovf_out}, 41'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 after release", {out_valid, acc_out}, 41'd0);
    chk("R8 ovf after release", {40'd0, ovf_out}, 41'd0);

    for (int i = 0; i < NV; i++) begin
      acc_in    = VEC[i].din;
      bias_mode = VEC[i].mode;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R%0d vec%0d value", VEC[i].req, i), {1'b0, acc_out}, {1'b0, VEC[i].exp});
      chk($sformatf("R5 vec%0d ovf", i), {40'd0, ovf_out}, {40'd0, VEC[i].eovf});
      chk($sformatf("R6 vec%0d out_valid", i), {40'd0, out_valid}, 41'd1);
    end

    // R7: inputs move while in_valid is low, output must not
    held      = acc_out;
    acc_in    = 40'h00_7FFF_8000;
    bias_mode = 1'b1;
    @(negedge clk);
    chk("R6 out_valid drops", {40'd0, out_valid}, 41'd0);
    chk("R7 value held", {1'b0, acc_out}, {1'b0, held});
    chk("R7 ovf held", {40'd0, ovf_out}, 41'd1);
    acc_in = 40'h00_0000_0001;
    repeat (3) @(negedge clk);
    chk("R7 value still held", {1'b0, acc_out}, {1'b0, held});

    // R6: back-to-back inputs give back-to-back results
    acc_in = 40'h00_0002_8000; bias_mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R6 b2b first", {out_valid, acc_out}, {1'b1, 40'h00_0002_0000});
    acc_in = 40'h00_0002_8000; bias_mode = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 b2b second", {out_valid, acc_out}, {1'b1, 40'h00_0003_0000});

    // R8: reset again clears the registered result
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 reassert", {out_valid, acc_out}, 41'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule